// File: doc/BRIEF.md
# ADC Result Compare Monitor

This block watches the stream of conversion results that an ADC sequencer writes into its result slots. It has a bank of comparators. Each comparator is tied to one slot and tests every new result for that slot against a 12-bit threshold. The test is either "below threshold" or "at or above threshold". Each comparator counts how many matching results arrive in a row. When the run reaches the programmed length, it raises a sticky flag and may request an interrupt.

An even-numbered comparator can be paired with the odd comparator above it in window mode. The pair then produces one flag, on the even index, and that flag counts only results that satisfy both conditions at once. This is normally used as a band check, with a lower limit on one comparator and an upper limit on the other.

Software writes one comparator's whole setting at a time through a configuration port. It clears flags through a separate write-one-to-clear mask. Result storage and the conversion itself stay outside this block.

Top module: `adc_cmp_monitor`

## Requirements
- R1: After synchronous reset, all compare flags are 0 and the interrupt request is 0.
- R2: With condition bit 0, a result matches only when it is strictly below the threshold, so a result equal to the threshold does not match.
- R3: With condition bit 1, a result matches when it is greater than or equal to the threshold, so a result equal to the threshold matches.
- R4: The match-count field holds the required run length minus one. The flag is set on the clock edge that samples the (count+1)-th consecutive match, which makes it visible from the next cycle. With a count of 0, the first match sets the flag.
- R5: A non-matching result written to the monitored slot resets that comparator's run to zero.
- R6: A result written to any other slot leaves the run and the flag of a comparator unchanged.
- R7: When a comparator sets its flag, its run restarts from zero, so another full run is needed before it can set again.
- R8: `flag_clr` clears each flag whose bit is 1 and leaves flags whose bit is 0 untouched. A set on the same edge takes precedence over a clear.
- R9: `irq` is high exactly while some flag is 1 and that comparator's interrupt-enable bit is 1.
- R10: Window mode exists only on even comparators. With it enabled, comparator 2k counts a result from its own slot as a match only if that result also passes comparator 2k+1's condition and threshold, and comparator 2k+1 is enabled. The window bit written to an odd comparator is ignored.
- R11: A configuration write with the enable bit 0 clears that comparator's whole setting to zero, interrupt enable included. The comparator's existing flag is kept, and no further result can set that flag.
- R12: Any configuration write to a comparator restarts its run from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_vld | input | 1 | Result-write strobe |
| res_slot | input | 5 | Slot index of the written result |
| res_data | input | 12 | Result value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Comparator being configured |
| cfg_en | input | 1 | Comparator enable; 0 clears the whole setting |
| cfg_slot | input | 5 | Monitored slot, 0 to 18 |
| cfg_cond | input | 1 | 0: below threshold, 1: at or above threshold |
| cfg_thr | input | 12 | Threshold |
| cfg_mcnt | input | 4 | Consecutive matches required, minus one |
| cfg_win | input | 1 | Window pairing (even comparators only) |
| cfg_ie | input | 1 | Interrupt enable |
| flag_clr | input | 4 | Write-one-to-clear mask for the flags |
| cmp_flag | output | 4 | Compare flags, bit i for comparator i |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: four comparators, 19 slots, 12-bit results and a 4-bit match count. These values bring both window pairs, the highest slot index 18, and thresholds at the edges of the 12-bit range within reach. Directed scenarios cover runs of length 1 and 3, a run broken by a miss, results on other slots, and window pass and fail on either side of the band. They also cover an odd comparator with its window bit set, counter restart on a configuration rewrite, and disable with a flag still pending.

// File: rtl/adcmon_pkg.sv
// Shared widths, the per-comparator configuration record and the threshold test.
// Assumes results and thresholds are unsigned and have the same width.
package adcmon_pkg;
    parameter int SLOT_W = 5;
    parameter int DATA_W = 12;
    parameter int MCNT_W = 4;

    typedef struct packed {
        logic              en;
        logic [SLOT_W-1:0] slot;
        logic              cond;
        logic [DATA_W-1:0] thr;
        logic [MCNT_W-1:0] mcnt;
        logic              win;
        logic              ie;
    } cmp_cfg_t;

    // Threshold test: cond 0 means strictly below, cond 1 means at or above.
    function automatic logic thr_pass(input logic cond,
                                      input logic [DATA_W-1:0] value,
                                      input logic [DATA_W-1:0] thr);
        return cond ? (value >= thr) : (value < thr);
    endfunction
endpackage

// File: rtl/adcmon_cfg_bank.sv
// Holds one configuration record per comparator.
// A write whose enable bit is 0 zeroes the record. The window bit is kept only
// on even comparators that have a partner above them.
// Assumes cfg_sel stays below NUM_CMP.
module adcmon_cfg_bank
    import adcmon_pkg::*;
#(
    parameter int NUM_CMP = 4,
    localparam int SEL_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [SEL_W-1:0]            sel,
    input  cmp_cfg_t                    wdata,
    output cmp_cfg_t [NUM_CMP-1:0]      cfg_q,
    output logic     [NUM_CMP-1:0]      wr_hit
);
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cfg
        localparam bit WIN_OK = ((i % 2) == 0) && (i + 1 < NUM_CMP);

        // Decode of the write strobe for this comparator.
        assign wr_hit[i] = we && (sel == SEL_W'(i));

        // Record register: cleared on disable, window bit dropped where unsupported.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[i] <= '0;
            end else if (wr_hit[i]) begin
                if (!wdata.en) begin
                    cfg_q[i] <= '0;
                end else begin
                    cfg_q[i]     <= wdata;
                    cfg_q[i].win <= WIN_OK ? wdata.win : 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/adcmon_eval.sv
// Decides, for each comparator, whether the current result write addresses it
// (hit) and whether the result satisfies its condition (pass). A window leader
// also needs its partner's condition to hold, and the partner to be enabled.
// Purely combinational.
module adcmon_eval
    import adcmon_pkg::*;
#(
    parameter int NUM_CMP   = 4,
    parameter int NUM_SLOTS = 19
) (
    input  logic                   res_vld,
    input  logic [SLOT_W-1:0]      res_slot,
    input  logic [DATA_W-1:0]      res_data,
    input  cmp_cfg_t [NUM_CMP-1:0] cfg_q,
    output logic     [NUM_CMP-1:0] hit,
    output logic     [NUM_CMP-1:0] pass
);
    logic slot_ok;
    logic [NUM_CMP-1:0] own_pass;

    // Results addressed to slots that do not exist reach no comparator.
    assign slot_ok = res_slot < SLOT_W'(NUM_SLOTS);

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_eval
        localparam bit WIN_OK = ((i % 2) == 0) && (i + 1 < NUM_CMP);

        // Own condition and slot match.
        assign own_pass[i] = thr_pass(cfg_q[i].cond, res_data, cfg_q[i].thr);
        assign hit[i]      = res_vld && slot_ok && cfg_q[i].en &&
                             (res_slot == cfg_q[i].slot);

        if (WIN_OK) begin : g_lead
            // Window leader: partner's test applies to the same result.
            assign pass[i] = cfg_q[i].win
                ? (own_pass[i] && cfg_q[i+1].en && own_pass[i+1])
                : own_pass[i];
        end else begin : g_solo
            assign pass[i] = own_pass[i];
        end
    end
endmodule

// File: rtl/adcmon_run.sv
// Consecutive-match counter for one comparator. It pulses set when the run
// reaches mcnt+1 and then restarts. A miss or a configuration write zeroes it.
module adcmon_run
    import adcmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              hit,
    input  logic              pass,
    input  logic [MCNT_W-1:0] mcnt,
    output logic              set_pulse,
    output logic [MCNT_W-1:0] cnt
);
    logic reached;

    // Terminal match: this hit completes the run.
    assign reached   = hit && pass && (cnt == mcnt);
    assign set_pulse = reached && !restart;

    // Run-length register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (hit) begin
            if (!pass || reached) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_cmp_monitor.sv
// Top of the compare monitor. It ties the configuration bank, the result
// evaluator and one run counter per comparator together, and holds the sticky
// flags. irq is a combinational OR over the enabled flags.
module adc_cmp_monitor
    import adcmon_pkg::*;
#(
    parameter int NUM_CMP   = 4,
    parameter int NUM_SLOTS = 19,
    localparam int SEL_W    = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               res_vld,
    input  logic [SLOT_W-1:0]  res_slot,
    input  logic [DATA_W-1:0]  res_data,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic               cfg_en,
    input  logic [SLOT_W-1:0]  cfg_slot,
    input  logic               cfg_cond,
    input  logic [DATA_W-1:0]  cfg_thr,
    input  logic [MCNT_W-1:0]  cfg_mcnt,
    input  logic               cfg_win,
    input  logic               cfg_ie,
    input  logic [NUM_CMP-1:0] flag_clr,
    output logic [NUM_CMP-1:0] cmp_flag,
    output logic               irq
);
    cmp_cfg_t                            wdata;
    cmp_cfg_t [NUM_CMP-1:0]              cfg_q;
    logic     [NUM_CMP-1:0]              wr_hit;
    logic     [NUM_CMP-1:0]              hit;
    logic     [NUM_CMP-1:0]              pass;
    logic     [NUM_CMP-1:0]              set_vec;
    logic     [NUM_CMP-1:0]              ie_vec;
    logic     [NUM_CMP-1:0][MCNT_W-1:0]  run_cnt;

    // Pack the configuration ports into one record.
    always_comb begin
        wdata      = '0;
        wdata.en   = cfg_en;
        wdata.slot = cfg_slot;
        wdata.cond = cfg_cond;
        wdata.thr  = cfg_thr;
        wdata.mcnt = cfg_mcnt;
        wdata.win  = cfg_win;
        wdata.ie   = cfg_ie;
    end

    adcmon_cfg_bank #(.NUM_CMP(NUM_CMP)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (wdata),
        .cfg_q  (cfg_q),
        .wr_hit (wr_hit)
    );

    adcmon_eval #(.NUM_CMP(NUM_CMP), .NUM_SLOTS(NUM_SLOTS)) u_eval (
        .res_vld  (res_vld),
        .res_slot (res_slot),
        .res_data (res_data),
        .cfg_q    (cfg_q),
        .hit      (hit),
        .pass     (pass)
    );

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_run
        adcmon_run u_run (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart   (wr_hit[i]),
            .hit       (hit[i]),
            .pass      (pass[i]),
            .mcnt      (cfg_q[i].mcnt),
            .set_pulse (set_vec[i]),
            .cnt       (run_cnt[i])
        );
        assign ie_vec[i] = cfg_q[i].ie;
    end

    // Sticky flags: a set on the same edge wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_flag <= '0;
        else        cmp_flag <= (cmp_flag & ~flag_clr) | set_vec;
    end

    // Interrupt request from any enabled flag.
    assign irq = |(cmp_flag & ie_vec);
endmodule

// File: rtl/adc_cmp_monitor_sva.sv
// Property checker for adc_cmp_monitor, attached by bind. It observes ports and
// the configuration and run state of the top.
module adc_cmp_monitor_sva
    import adcmon_pkg::*;
#(
    parameter int NUM_CMP = 4,
    localparam int SEL_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            res_vld,
    input logic [SLOT_W-1:0]               res_slot,
    input logic                            cfg_we,
    input logic [SEL_W-1:0]                cfg_sel,
    input logic                            cfg_en,
    input logic [NUM_CMP-1:0]              flag_clr,
    input logic [NUM_CMP-1:0]              cmp_flag,
    input logic                            irq,
    input cmp_cfg_t [NUM_CMP-1:0]          cfg_q,
    input logic [NUM_CMP-1:0][MCNT_W-1:0]  run_cnt
);
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cmp_flag != '0));

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_chk
        a_r4_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            run_cnt[i] <= cfg_q[i].mcnt);

        a_r4_set_after_result: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cmp_flag[i]) |-> $past(res_vld));

        a_r6_other_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (res_vld && !cfg_we && (res_slot != cfg_q[i].slot)) |=> !$rose(cmp_flag[i]));

        a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_clr[i] && !res_vld) |=> !cmp_flag[i]);

        a_r11_disable_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && !cfg_en && (cfg_sel == SEL_W'(i))) |=>
                ((cfg_q[i] == '0) && (run_cnt[i] == '0)));
    end
endmodule

bind adc_cmp_monitor adc_cmp_monitor_sva #(.NUM_CMP(NUM_CMP)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .res_vld  (res_vld),
    .res_slot (res_slot),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_en   (cfg_en),
    .flag_clr (flag_clr),
    .cmp_flag (cmp_flag),
    .irq      (irq),
    .cfg_q    (cfg_q),
    .run_cnt  (run_cnt)
);

// File: tb/adc_cmp_monitor_tb_top.sv
// Directed bench for adc_cmp_monitor: one task per scenario.
module adc_cmp_monitor_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        res_vld;
    logic [4:0]  res_slot;
    logic [11:0] res_data;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic        cfg_en;
    logic [4:0]  cfg_slot;
    logic        cfg_cond;
    logic [11:0] cfg_thr;
    logic [3:0]  cfg_mcnt;
    logic        cfg_win;
    logic        cfg_ie;
    logic [3:0]  flag_clr;
    logic [3:0]  cmp_flag;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    adc_cmp_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_slot(res_slot),
        .res_data(res_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
        .cfg_slot(cfg_slot), .cfg_cond(cfg_cond), .cfg_thr(cfg_thr),
        .cfg_mcnt(cfg_mcnt), .cfg_win(cfg_win), .cfg_ie(cfg_ie),
        .flag_clr(flag_clr), .cmp_flag(cmp_flag), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // Each driver task ends on the falling edge after the sampling edge.
    task automatic cfg(input int idx, input bit en, input int slot, input bit cond,
                       input int thr, input int mcnt, input bit win, input bit ie);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(idx); cfg_en = en; cfg_slot = 5'(slot);
        cfg_cond = cond; cfg_thr = 12'(thr); cfg_mcnt = 4'(mcnt);
        cfg_win = win; cfg_ie = ie;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put(input int slot, input int data);
        @(negedge clk);
        res_vld = 1'b1; res_slot = 5'(slot); res_data = 12'(data);
        @(negedge clk);
        res_vld = 1'b0;
    endtask

    task automatic clr(input logic [3:0] m);
        @(negedge clk);
        flag_clr = m;
        @(negedge clk);
        flag_clr = '0;
    endtask

    task automatic t_reset;
        check("R1 flags after reset", 32'(cmp_flag), 0);
        check("R1 irq after reset", 32'(irq), 0);
    endtask

    task automatic t_less;
        cfg(0, 1, 3, 0, 'h100, 0, 0, 1);
        put(3, 'h0FF);
        check("R2 below threshold sets, R4 count 0", 32'(cmp_flag), 4'b0001);
        check("R9 irq with enabled flag", 32'(irq), 1);
        clr(4'b0001);
        check("R8 clear flag 0", 32'(cmp_flag), 0);
        check("R9 irq drops with flag", 32'(irq), 0);
        put(3, 'h100);
        check("R2 equal does not match", 32'(cmp_flag), 0);
    endtask

    task automatic t_ge_run;
        cfg(1, 1, 18, 1, 'h800, 2, 0, 0);
        put(18, 'h800);
        put(18, 'h800);
        check("R4 two of three matches", 32'(cmp_flag), 0);
        put(5, 'h000);
        check("R6 other slot ignored", 32'(cmp_flag), 0);
        put(18, 'hFFF);
        check("R3 R4 R6 third match sets flag 1", 32'(cmp_flag), 4'b0010);
        check("R9 no irq with ie 0", 32'(irq), 0);
        clr(4'b0010);
        put(18, 'h900);
        put(18, 'h900);
        check("R7 run restarted after set", 32'(cmp_flag), 0);
        put(18, 'h900);
        check("R7 full run sets again", 32'(cmp_flag), 4'b0010);
        clr(4'b0010);
    endtask

    task automatic t_miss;
        put(18, 'h900);
        put(18, 'h900);
        put(18, 'h7FF);
        put(18, 'h900);
        put(18, 'h900);
        check("R5 miss resets run", 32'(cmp_flag), 0);
        put(18, 'h900);
        check("R5 run completes after miss", 32'(cmp_flag), 4'b0010);
        put(3, 'h010);
        check("R8 two flags set", 32'(cmp_flag), 4'b0011);
        clr(4'b0001);
        check("R8 mask clears only bit 0", 32'(cmp_flag), 4'b0010);
        clr(4'b1111);
    endtask

    task automatic t_window;
        cfg(2, 1, 7, 1, 'h200, 0, 1, 1);
        cfg(3, 1, 9, 0, 'h600, 0, 0, 0);
        put(7, 'h100);
        check("R10 below band no flag", 32'(cmp_flag), 0);
        put(7, 'h700);
        check("R10 above band no flag", 32'(cmp_flag), 0);
        put(7, 'h400);
        check("R10 inside band sets flag 2 only", 32'(cmp_flag), 4'b0100);
        clr(4'b0100);
        cfg(0, 0, 0, 0, 0, 0, 0, 0);
        cfg(1, 1, 4, 0, 'h050, 0, 1, 0);
        put(4, 'h010);
        check("R10 window bit on odd ignored", 32'(cmp_flag), 4'b0010);
        clr(4'b1111);
    endtask

    task automatic t_restart;
        cfg(0, 1, 2, 1, 0, 1, 0, 1);
        put(2, 5);
        check("R12 first of two", 32'(cmp_flag), 0);
        cfg(0, 1, 2, 1, 0, 1, 0, 1);
        put(2, 5);
        check("R12 rewrite restarted run", 32'(cmp_flag), 0);
        put(2, 5);
        check("R12 run completes", 32'(cmp_flag), 4'b0001);
    endtask

    task automatic t_disable;
        check("R9 irq before disable", 32'(irq), 1);
        cfg(0, 0, 2, 1, 0, 1, 0, 1);
        check("R11 ie cleared so irq low", 32'(irq), 0);
        check("R11 flag kept", 32'(cmp_flag), 4'b0001);
        clr(4'b0001);
        put(2, 5);
        put(2, 5);
        put(0, 0);
        check("R11 disabled comparator silent", 32'(cmp_flag), 0);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; res_vld = 1'b0; res_slot = '0; res_data = '0;
        cfg_we = 1'b0; cfg_sel = '0; cfg_en = 1'b0; cfg_slot = '0;
        cfg_cond = 1'b0; cfg_thr = '0; cfg_mcnt = '0; cfg_win = 1'b0;
        cfg_ie = 1'b0; flag_clr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_less();
        t_ge_run();
        t_miss();
        t_window();
        t_restart();
        t_disable();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule